// File: doc/BRIEF.md
# Multiphase Interleaved PWM Generator with Transient Override

This block drives the gate signals of a core-voltage regulator built from three to six parallel power phases. A single period counter sets the switching period. Each active phase runs its own copy of that period, shifted by an equal fraction so that the phases are spread evenly around the cycle. A duty command arrives from an external compensation path. The block then corrects that command separately for each phase, using the phase's 6-bit current sample, so that phases carrying more than the mean current are shortened and phases carrying less are lengthened.

Two transient flags let a load-step detector bypass the modulator. A high-side transient turns every active phase on at once, which raises the output as fast as possible. A low-side transient turns every phase off. Normal interleaved switching comes back at the next period boundary after the flags drop. Each phase has a high-side drive and a complementary low-side drive. A programmable dead time separates them at every change of the high-side command. A global enable forces every drive low.

Top module: `mpwm_core`

## Requirements
- R1: The requested phase count `n_active` is clamped to the range 3..6, giving N. Phase indices N and above keep both drives low at all times.
- R2: The period counter counts 0..P-1 and wraps, where P is `period`. Phase i has start tick floor(i*P/N). Its local tick is the counter minus the start tick, taken modulo P.
- R3: The mean current is the floor of the sum of the active phases' samples divided by N. Phase i's duty is `duty` + (mean - cur_i) * `gain`, clamped to the range 0..P. The high-side command of a phase is 1 while its local tick is below that duty. The drive outputs follow the command one clock after the inputs are sampled.
- R4: A high-side transient flag sampled at edge k puts the block in all-on mode. The command register then equals the active-phase mask from edge k+1 on.
- R5: A low-side transient flag puts the block in all-off mode, and it wins over the high-side flag when both are set. The high-side drives are 0 two edges after the flag is sampled.
- R6: All-on and all-off modes persist after the flags drop. Normal mode returns at the edge where the counter wraps from P-1 to 0.
- R7: The low-side drive is 1 when the phase is active, the block is enabled and the command is 0. Each change of command blanks both drives for `dead` cycles. High-side and low-side are never 1 together.
- R8: While `en` is 0, the counter is held at 0, the mode is normal, the transient flags are ignored, and both drives of every phase are 0 from the next edge on.
- R9: During reset, every drive output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Global enable |
| n_active | input | 3 | Requested phase count (clamped to 3..6) |
| period | input | 10 | Switching period in clock counts |
| duty | input | 10 | Base duty command in counts |
| gain | input | 4 | Current-balance gain |
| dead | input | 4 | Dead time in cycles |
| cur | input | 36 | Six 6-bit phase current samples, phase 0 in the low bits |
| trans_hi | input | 1 | High-side transient flag (all phases on) |
| trans_lo | input | 1 | Low-side transient flag (all phases off) |
| pwm_hi | output | 6 | High-side drive per phase |
| pwm_lo | output | 6 | Low-side drive per phase |

## Verification
Two events can land on the same edge: a transient flag dropping, and the period counter wrapping. Whether normal switching resumes at once or one period later depends on which of the two the design honours. The bench holds the high-side flag and then clears it exactly on the cycle where its reference model shows the counter at P-1. It also raises both flags together so that the priority between them is tested. Random segments add sparse flag pulses at arbitrary phases of the period. Every cycle the bench compares all twelve drive bits against a cycle model built from the requirements, so a one-cycle slip in returning to normal mode shows up as a miscompare.

// File: rtl/mpwm_pkg.sv
package mpwm_pkg;

  typedef enum logic [1:0] {
    OVR_NONE = 2'd0,
    OVR_ON   = 2'd1,
    OVR_OFF  = 2'd2
  } ovr_t;

  // Clamp a requested count into [lo, hi].
  function automatic int clamp_count(int req, int lo, int hi);
    if (req < lo) return lo;
    if (req > hi) return hi;
    return req;
  endfunction

  // Start tick of a phase inside the shared period.
  function automatic int slot_start(int idx, int per, int n);
    return (idx * per) / n;
  endfunction

  // Position of a phase inside its own shifted period.
  function automatic int slot_tick(int c, int per, int start);
    int t;
    t = c - start;
    if (t < 0) t = t + per;
    return t;
  endfunction

  // Mean of the active samples.
  function automatic int mean_of(int total, int n);
    return total / n;
  endfunction

  // Balance-corrected duty, clamped to [0, per].
  function automatic int trim_duty(int base, int mean, int own, int g, int per);
    int v;
    v = base + (mean - own) * g;
    if (v < 0) v = 0;
    if (v > per) v = per;
    return v;
  endfunction

endpackage

// File: rtl/mpwm_seq.sv
module mpwm_seq
  import mpwm_pkg::*;
#(
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [CW-1:0] period,
  input  logic          trans_hi,
  input  logic          trans_lo,
  output logic [CW-1:0] cnt,
  output logic          wrap,
  output ovr_t          mode
);

  ovr_t mode_nx;

  always_comb wrap = en && (int'(cnt) >= int'(period) - 1);

  // Low-side flag has priority; a held override releases only on a wrap.
  always_comb begin
    if (trans_lo)      mode_nx = OVR_OFF;
    else if (trans_hi) mode_nx = OVR_ON;
    else if (wrap)     mode_nx = OVR_NONE;
    else               mode_nx = mode;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      mode <= OVR_NONE;
    end else if (!en) begin
      cnt  <= '0;
      mode <= OVR_NONE;
    end else begin
      cnt  <= wrap ? '0 : cnt + CW'(1);
      mode <= mode_nx;
    end
  end

endmodule

// File: rtl/mpwm_bal.sv
module mpwm_bal
  import mpwm_pkg::*;
#(
  parameter int NPH = 6,
  parameter int IW  = 6,
  parameter int CW  = 10,
  parameter int GW  = 4,
  parameter int PHW = 3
) (
  input  logic [NPH*IW-1:0] cur,
  input  logic [NPH-1:0]    act,
  input  logic [PHW-1:0]    neff,
  input  logic [CW-1:0]     duty,
  input  logic [GW-1:0]     gain,
  input  logic [CW-1:0]     period,
  output logic [NPH*CW-1:0] trim
);

  logic [IW-1:0] mean;

  always_comb begin
    int total;
    total = 0;
    for (int i = 0; i < NPH; i++) begin
      if (act[i]) total = total + int'(cur[i*IW +: IW]);
    end
    mean = IW'(mean_of(total, int'(neff)));
  end

  for (genvar g = 0; g < NPH; g++) begin : g_trim
    always_comb
      trim[g*CW +: CW] = CW'(trim_duty(int'(duty), int'(mean),
                                       int'(cur[g*IW +: IW]),
                                       int'(gain), int'(period)));
  end

endmodule

// File: rtl/mpwm_leg.sv
module mpwm_leg
  import mpwm_pkg::*;
#(
  parameter int CW = 10,
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          act,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] period,
  input  logic [CW-1:0] start,
  input  logic [CW-1:0] trim,
  input  ovr_t          mode,
  input  logic [DW-1:0] dead,
  output logic          hs,
  output logic          ls,
  output logic          cmd_q,
  output logic          act_q
);

  logic          want;
  logic          en_q;
  logic          settled;
  logic [DW-1:0] dtc;

  always_comb begin
    if (!en || !act) want = 1'b0;
    else begin
      case (mode)
        OVR_ON:  want = 1'b1;
        OVR_OFF: want = 1'b0;
        default: want = slot_tick(int'(cnt), int'(period), int'(start)) < int'(trim);
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= 1'b0;
      act_q <= 1'b0;
      en_q  <= 1'b0;
      dtc   <= '0;
    end else begin
      cmd_q <= want;
      act_q <= act;
      en_q  <= en;
      if (want != cmd_q)  dtc <= dead;
      else if (dtc != '0) dtc <= dtc - DW'(1);
    end
  end

  always_comb begin
    settled = (dtc == '0);
    hs      = cmd_q & settled;
    ls      = en_q & act_q & ~cmd_q & settled;
  end

endmodule

// File: rtl/mpwm_core.sv
module mpwm_core
  import mpwm_pkg::*;
#(
  parameter int NPH    = 6,
  parameter int MIN_PH = 3,
  parameter int IW     = 6,
  parameter int CW     = 10,
  parameter int GW     = 4,
  parameter int DW     = 4,
  localparam int PHW   = $clog2(NPH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [PHW-1:0]    n_active,
  input  logic [CW-1:0]     period,
  input  logic [CW-1:0]     duty,
  input  logic [GW-1:0]     gain,
  input  logic [DW-1:0]     dead,
  input  logic [NPH*IW-1:0] cur,
  input  logic              trans_hi,
  input  logic              trans_lo,
  output logic [NPH-1:0]    pwm_hi,
  output logic [NPH-1:0]    pwm_lo
);

  logic [PHW-1:0]    neff;
  logic [NPH-1:0]    act;
  logic [CW-1:0]     cnt;
  logic              period_end;
  ovr_t              ovr_mode;
  logic [NPH*CW-1:0] trim;
  logic [NPH-1:0]    leg_cmd;
  logic [NPH-1:0]    leg_act;

  always_comb neff = PHW'(clamp_count(int'(n_active), MIN_PH, NPH));

  mpwm_seq #(.CW(CW)) u_seq (
    .clk(clk), .rst_n(rst_n), .en(en), .period(period),
    .trans_hi(trans_hi), .trans_lo(trans_lo),
    .cnt(cnt), .wrap(period_end), .mode(ovr_mode)
  );

  mpwm_bal #(.NPH(NPH), .IW(IW), .CW(CW), .GW(GW), .PHW(PHW)) u_bal (
    .cur(cur), .act(act), .neff(neff), .duty(duty),
    .gain(gain), .period(period), .trim(trim)
  );

  for (genvar g = 0; g < NPH; g++) begin : g_leg
    logic [CW-1:0] start;
    always_comb act[g] = (g < int'(neff));
    always_comb start  = CW'(slot_start(g, int'(period), int'(neff)));

    mpwm_leg #(.CW(CW), .DW(DW)) u_leg (
      .clk(clk), .rst_n(rst_n), .en(en), .act(act[g]),
      .cnt(cnt), .period(period), .start(start),
      .trim(trim[g*CW +: CW]), .mode(ovr_mode), .dead(dead),
      .hs(pwm_hi[g]), .ls(pwm_lo[g]),
      .cmd_q(leg_cmd[g]), .act_q(leg_act[g])
    );
  end

endmodule

// File: rtl/mpwm_core_chk.sv
module mpwm_core_chk
  import mpwm_pkg::*;
#(
  parameter int NPH = 6
) (
  input logic           clk,
  input logic           rst_n,
  input logic           en,
  input logic           trans_hi,
  input logic           trans_lo,
  input logic           period_end,
  input ovr_t           ovr_mode,
  input logic [NPH-1:0] pwm_hi,
  input logic [NPH-1:0] pwm_lo,
  input logic [NPH-1:0] leg_cmd,
  input logic [NPH-1:0] leg_act
);

  // R7
  no_shoot_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_hi & pwm_lo) == '0);

  // R1
  idle_legs_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pwm_hi | pwm_lo) & ~leg_act) == '0);

  // R8
  off_when_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (pwm_hi == '0 && pwm_lo == '0));

  // R5
  lo_transient_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && trans_lo) |-> ##2 (pwm_hi == '0));

  // R4
  hi_transient_aligns_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && trans_hi && !trans_lo) ##1 en |-> ##1 (leg_cmd == leg_act));

  // R6
  resume_at_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (period_end && !trans_hi && !trans_lo) |=> (ovr_mode == OVR_NONE));

endmodule

bind mpwm_core mpwm_core_chk #(.NPH(NPH)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .trans_hi(trans_hi), .trans_lo(trans_lo),
  .period_end(period_end), .ovr_mode(ovr_mode),
  .pwm_hi(pwm_hi), .pwm_lo(pwm_lo), .leg_cmd(leg_cmd), .leg_act(leg_act)
);

// File: tb/sim_mpwm_core.sv
module sim_mpwm_core;
  localparam int CLK_PERIOD = 10;
  localparam int NPH = 6;
  localparam int IW  = 6;
  localparam int CW  = 10;
  localparam int GW  = 4;
  localparam int DW  = 4;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              en;
  logic [2:0]        n_active;
  logic [CW-1:0]     period;
  logic [CW-1:0]     duty;
  logic [GW-1:0]     gain;
  logic [DW-1:0]     dead;
  logic [NPH*IW-1:0] cur;
  logic              trans_hi;
  logic              trans_lo;
  logic [NPH-1:0]    pwm_hi;
  logic [NPH-1:0]    pwm_lo;

  int    n_vec  = 0;
  int    n_bad  = 0;
  bit    live   = 0;
  string cur_req = "R9";

  always #(CLK_PERIOD/2) clk = ~clk;

  mpwm_core #(.NPH(NPH), .IW(IW), .CW(CW), .GW(GW), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .n_active(n_active), .period(period),
    .duty(duty), .gain(gain), .dead(dead), .cur(cur),
    .trans_hi(trans_hi), .trans_lo(trans_lo), .pwm_hi(pwm_hi), .pwm_lo(pwm_lo)
  );

  // ---------------- reference functions ----------------
  function automatic int ph_count(int req);
    return (req < 3) ? 3 : ((req > NPH) ? NPH : req);
  endfunction

  function automatic int sample(int i);
    return int'(cur[i*IW +: IW]);
  endfunction

  function automatic int want_duty(int i, int n, int p);
    int acc, avg, d;
    acc = 0;
    for (int k = 0; k < n; k++) acc += sample(k);
    avg = acc / n;
    d = int'(duty) + int'(gain) * (avg - sample(i));
    return (d > p) ? p : ((d < 0) ? 0 : d);
  endfunction

  // ---------------- cycle model ----------------
  int m_cnt;
  int m_mode;                 // 0 normal, 1 all on, 2 all off
  bit m_en;
  bit m_cmd [NPH];
  bit m_act [NPH];
  int m_dtc [NPH];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_mode = 0; m_en = 0;
      for (int i = 0; i < NPH; i++) begin m_cmd[i] = 0; m_act[i] = 0; m_dtc[i] = 0; end
    end else begin
      int n, p;
      bit w;
      n = ph_count(int'(n_active));
      p = int'(period);
      for (int i = 0; i < NPH; i++) begin
        if (!en || i >= n)    w = 0;
        else if (m_mode == 1) w = 1;
        else if (m_mode == 2) w = 0;
        else w = (((m_cnt - (i * p) / n) % p + p) % p) < want_duty(i, n, p);
        if (w != m_cmd[i])    m_dtc[i] = int'(dead);
        else if (m_dtc[i] > 0) m_dtc[i] = m_dtc[i] - 1;
        m_cmd[i] = w;
        m_act[i] = (i < n);
      end
      m_en = en;
      if (!en) begin
        m_cnt = 0; m_mode = 0;
      end else begin
        bit last;
        last = (m_cnt >= p - 1);
        if (trans_lo)      m_mode = 2;
        else if (trans_hi) m_mode = 1;
        else if (last)     m_mode = 0;
        m_cnt = last ? 0 : m_cnt + 1;
      end
    end
  end

  task automatic check(string req, logic [2*NPH-1:0] got, logic [2*NPH-1:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s t=%0t got hi/lo=%b expected %b", req, $time, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (live) begin
      logic [NPH-1:0] eh, el;
      for (int i = 0; i < NPH; i++) begin
        eh[i] = m_cmd[i] && (m_dtc[i] == 0);
        el[i] = m_en && m_act[i] && !m_cmd[i] && (m_dtc[i] == 0);
      end
      check(cur_req, {pwm_hi, pwm_lo}, {eh, el});
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic run(int c);
    repeat (c) @(negedge clk);
  endtask

  task automatic set_cur(int i, int v);
    cur[i*IW +: IW] = IW'(v);
  endtask

  task automatic cfg(int p, int n, int d, int g, int dt);
    @(negedge clk);
    en = 0; trans_hi = 0; trans_lo = 0;
    run(20);
    period = CW'(p); n_active = 3'(n); duty = CW'(d); gain = GW'(g); dead = DW'(dt);
    en = 1;
  endtask

  task automatic run_rand(int c);
    repeat (c) begin
      @(negedge clk);
      trans_hi = ($urandom % 60) == 0;
      trans_lo = ($urandom % 90) == 0;
    end
    @(negedge clk);
    trans_hi = 0; trans_lo = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 0; en = 0; n_active = 3'd4; period = CW'(40); duty = CW'(15);
    gain = '0; dead = '0; cur = '0; trans_hi = 0; trans_lo = 0;
    run(3);
    // R9: outputs quiet in reset
    check("R9", {pwm_hi, pwm_lo}, '0);
    @(negedge clk);
    rst_n = 1;
    live = 1;

    // R2: balanced currents, plain interleave
    cur_req = "R2";
    for (int i = 0; i < NPH; i++) set_cur(i, 20);
    cfg(40, 4, 15, 0, 0);
    run(200);

    // R1: count clamps low and high
    cur_req = "R1";
    cfg(45, 1, 20, 0, 0);
    run(120);
    check("R1", {pwm_hi[5:3], pwm_lo[5:3]}, '0);
    cfg(45, 7, 20, 0, 0);
    run(120);

    // R3: unequal currents, trim, clamps
    cur_req = "R3";
    set_cur(0, 10); set_cur(1, 40); set_cur(2, 25); set_cur(3, 63); set_cur(4, 0); set_cur(5, 30);
    cfg(60, 6, 25, 3, 0);
    run(300);
    cfg(60, 5, 900, 1, 0);
    run(150);
    cfg(60, 6, 2, 15, 0);
    run(150);

    // R7: dead time
    cur_req = "R7";
    cfg(50, 3, 20, 2, 5);
    run(300);

    // R4: high transient aligns all active phases
    cur_req = "R4";
    cfg(48, 6, 10, 0, 0);
    run(17);
    trans_hi = 1;
    @(negedge clk);
    trans_hi = 0;
    @(negedge clk);
    check("R4", {26'd0, pwm_hi}, {26'd0, 6'b111111});
    run(150);

    // R5: low transient, and both flags together
    cur_req = "R5";
    run(11);
    trans_lo = 1;
    @(negedge clk);
    trans_lo = 0;
    @(negedge clk);
    check("R5", {26'd0, pwm_hi}, '0);
    run(60);
    trans_hi = 1; trans_lo = 1;
    @(negedge clk);
    trans_hi = 0; trans_lo = 0;
    @(negedge clk);
    check("R5", {26'd0, pwm_hi}, '0);
    run(120);

    // R6: flag drops exactly on the wrap cycle, and mid-period
    cur_req = "R6";
    trans_hi = 1;
    run(30);
    while (m_cnt != 47) @(negedge clk);
    trans_hi = 0;
    run(100);
    trans_lo = 1;
    run(5);
    trans_lo = 0;
    run(120);

    // R8: enable drop
    cur_req = "R8";
    cfg(40, 5, 18, 1, 2);
    run(57);
    en = 0;
    @(negedge clk);
    check("R8", {pwm_hi, pwm_lo}, '0);
    trans_hi = 1;
    run(10);
    trans_hi = 0;
    en = 1;
    run(120);

    // random segments
    cur_req = "R3";
    for (int s = 0; s < 14; s++) begin
      for (int i = 0; i < NPH; i++) set_cur(i, int'($urandom % 64));
      begin
        int p;
        p = 133 + int'($urandom % 401);
        cfg(p, int'($urandom % 8), int'($urandom % (p + 40)),
            int'($urandom % 16), int'($urandom % 16));
        run_rand(2 * p);
      end
    end

    live = 0;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule